// File: doc/BRIEF.md
# Cascaded Layer Read-Data Chain

This block models the read-data return path of a vertical stack of memory layers, with layer 0 at the bottom and the top layer numbered N-1. Each layer contributes one word per access. Words travel down the stack one stage at a time over segmented links. Each stage holds a link register, its own slot counter and a two-way selector. The selector either loads the layer's own word or latches the word that the stage above has just presented. The bottom stage drives the external channel.

Everything runs in one fast clock. A frame is N slots long. Layer k is enabled in the first N-k slots of every frame and holds its link register in the rest. This stands in for the lower transfer rate of the upper layers. In slot 0 every stage loads its own word. In each later enabled slot, a stage forwards whatever the stage above latched in the slot before. The channel therefore carries one word per cycle, in layer order 0 to N-1, and each word is tagged with its layer.

Input side: all layers offer their words on one shared acceptance strobe, `in_ready`. `in_ready` does not depend on `in_valid`. A layer's word is taken at a rising edge where `in_ready` is high. If that layer's `in_valid` bit is low at that edge, the layer has nothing to send this frame. A source that is not yet accepted holds its word until the next `in_ready`. The output side has no back-pressure: the sink must take one word in every cycle in which `out_valid` is high.

Top module: `lchain_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is high in exactly one cycle of every N. The first such cycle is the cycle right after reset is released, and the high cycles follow each other with a period of exactly N cycles.
- R3: The words accepted at one `in_ready` edge appear on the output in the N cycles that follow that edge, bottom layer first. Layer k's word is visible in cycle k+1 after the edge.
- R4: `out_tag` carries the index of the source layer as an unsigned binary number: 0 for the bottom layer, N-1 for the top layer.
- R5: When layer k's `in_valid` bit is 1 at the acceptance edge, its output slot has `out_valid` = 1 and `out_data` equal to `in_data[k*W +: W]` as it was at that edge.
- R6: When layer k's `in_valid` bit is 0 at the acceptance edge, its output slot has `out_valid` = 0, `out_data` = 0 and `out_tag` = k. The slots of the other layers stay where they are and keep their contents.
- R7: Frames accepted at consecutive `in_ready` cycles leave the channel back to back. When every layer is valid, `out_valid` stays high in every cycle, with no gap between frames.
- R8: `in_data` and `in_valid` are ignored in cycles where `in_ready` is low. The top layer's link register changes only in the cycle that follows an acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast channel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N | Per-layer word-present flag; bit k belongs to layer k |
| in_data | input | N*W | Per-layer words; layer k occupies bits k*W +: W |
| in_ready | output | 1 | Acceptance strobe shared by all layers, high once per frame |
| out_valid | output | 1 | Current channel slot carries a word |
| out_tag | output | max(1,clog2(N)) | Source layer of the current slot |
| out_data | output | W | Channel word, zero in an empty slot |

## Verification
The chain is driven with frames in which all layers are valid and hold random words. These show the layer order, the tags, the per-slot latency and the contents. Run back to back, the same frames show that no bubble appears between frames. Several `in_valid` masks are used: alternate layers empty, every layer empty, and only the top layer empty. These separate gating of a layer's own slot from any shift of the slots that follow it. In one frame the inputs are scrambled in every cycle except the acceptance cycle. This shows that only the sampled words reach the channel.

// File: rtl/lchain_pkg.sv
package lchain_pkg;

  // A stage at height 'layer' is active in the first n-layer slots of a frame.
  function automatic logic slot_on(input int layer, input int slot, input int n);
    return (slot + layer) < n;
  endfunction

endpackage

// File: rtl/lchain_slot_ctr.sv
module lchain_slot_ctr #(
  parameter int unsigned N  = 4,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot,
  output logic          first
);

  localparam logic [SW-1:0] LAST = SW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
    end else if (slot == LAST) begin
      slot <= '0;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  assign first = (slot == '0);

endmodule

// File: rtl/lchain_stage.sv
module lchain_stage
  import lchain_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned N     = 4,
  parameter int unsigned LAYER = 0,
  localparam int unsigned SW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  own_data,
  input  logic          own_valid,
  input  logic [W-1:0]  up_data,
  input  logic          up_valid,
  input  logic [SW-1:0] up_tag,
  output logic [W-1:0]  dn_data,
  output logic          dn_valid,
  output logic [SW-1:0] dn_tag,
  output logic          take_own
);

  localparam logic [SW-1:0] MY_TAG = SW'(LAYER);

  logic [SW-1:0] slot;
  logic          first;
  logic          active;

  // Local slot counter: the enable of this layer is derived from it.
  lchain_slot_ctr #(.N(N)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .slot  (slot),
    .first (first)
  );

  assign active   = slot_on(int'(LAYER), int'(slot), int'(N));
  assign take_own = first;

  // Link register: own word in slot 0, latched upstream word afterwards,
  // held in slots where this layer is idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      dn_data  <= '0;
      dn_valid <= 1'b0;
      dn_tag   <= '0;
    end else if (active) begin
      if (first) begin
        dn_data  <= own_valid ? own_data : '0;
        dn_valid <= own_valid;
        dn_tag   <= MY_TAG;
      end else begin
        dn_data  <= up_data;
        dn_valid <= up_valid;
        dn_tag   <= up_tag;
      end
    end
  end

endmodule

// File: rtl/lchain_top.sv
module lchain_top #(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 4,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   in_valid,
  input  logic [N*W-1:0] in_data,
  output logic           in_ready,
  output logic           out_valid,
  output logic [SW-1:0]  out_tag,
  output logic [W-1:0]   out_data
);

  logic [W-1:0]  dn_data  [N];
  logic          dn_valid [N];
  logic [SW-1:0] dn_tag   [N];
  logic [N-1:0]  take_w;

  for (genvar k = 0; k < N; k++) begin : g_layer
    logic [W-1:0]  up_d;
    logic          up_v;
    logic [SW-1:0] up_t;

    if (k == N - 1) begin : g_top
      assign up_d = '0;
      assign up_v = 1'b0;
      assign up_t = '0;
    end else begin : g_mid
      assign up_d = dn_data[k+1];
      assign up_v = dn_valid[k+1];
      assign up_t = dn_tag[k+1];
    end

    lchain_stage #(.W(W), .N(N), .LAYER(k)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .own_data  (in_data[k*W +: W]),
      .own_valid (in_valid[k]),
      .up_data   (up_d),
      .up_valid  (up_v),
      .up_tag    (up_t),
      .dn_data   (dn_data[k]),
      .dn_valid  (dn_valid[k]),
      .dn_tag    (dn_tag[k]),
      .take_own  (take_w[k])
    );
  end

  // All stage counters share one frame; acceptance needs all of them at slot 0.
  assign in_ready  = &take_w;
  assign out_valid = dn_valid[0];
  assign out_tag   = dn_tag[0];
  assign out_data  = dn_data[0];

endmodule

// File: rtl/lchain_chk.sv
module lchain_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 4,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   in_valid,
  input logic [N*W-1:0] in_data,
  input logic           in_ready,
  input logic           out_valid,
  input logic [SW-1:0]  out_tag,
  input logic [W-1:0]   out_data,
  input logic [W-1:0]   top_link
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  ready_single_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  // R3
  frame_head_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_ready) |-> out_tag == '0);

  // R4
  tag_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_ready) |-> out_tag == SW'($past(out_tag) + 1'b1));

  // R5
  head_data_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid[0]) |=> (out_valid && out_data == $past(in_data[W-1:0])));

  // R6
  head_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid[0]) |=> (!out_valid && out_data == '0));

  // R8
  top_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_ready) |-> $stable(top_link));

endmodule

bind lchain_top lchain_chk #(.W(W), .N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_tag   (out_tag),
  .out_data  (out_data),
  .top_link  (dn_data[N-1])
);

// File: tb/test_lchain_top.sv
`timescale 1ns/1ps
module test_lchain_top;

  localparam int N  = 4;
  localparam int W  = 32;
  localparam int SW = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   in_valid = '0;
  logic [N*W-1:0] in_data = '0;
  logic           in_ready;
  logic           out_valid;
  logic [SW-1:0]  out_tag;
  logic [W-1:0]   out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lchain_top #(.W(W), .N(N)) i_lchain_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h at %0t", req, got, exp, $time);
    end
  endtask

  // Called at a negedge where in_ready must be high; returns at the negedge
  // where the next frame may be offered.
  task automatic run_frame(input logic [N-1:0] mask, input bit scramble, input bit gapless);
    logic [W-1:0] w [N];
    chk(in_ready === 1'b1, "R2 ready at frame start", in_ready, 1);
    for (int k = 0; k < N; k++) begin
      w[k] = $urandom;
      in_data[k*W +: W] = w[k];
    end
    in_valid = mask;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      chk(out_tag == SW'(i), "R3 R4 layer order and tag", out_tag, i);
      chk(out_valid == mask[i], mask[i] ? "R5 slot valid" : "R6 empty slot", out_valid, mask[i]);
      chk(out_data == (mask[i] ? w[i] : '0), mask[i] ? "R5 slot data" : "R6 empty data", out_data, mask[i] ? w[i] : 0);
      if (gapless)
        chk(out_valid == 1'b1, "R7 no gap", out_valid, 1);
      chk(in_ready == (i == N - 1), "R2 ready cadence", in_ready, i == N - 1);
      if (scramble && i < N - 1) begin
        in_data  = {$urandom, $urandom, $urandom, $urandom};
        in_valid = ~mask;
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 idle in reset", out_valid, 0);
    end
    in_valid = '1;
    rst = 1'b0;
    chk(out_valid == 1'b0, "R1 idle after release", out_valid, 0);
    chk(in_ready == 1'b1, "R1 ready after release", in_ready, 1);
  endtask

  task automatic t_full_frames();
    for (int f = 0; f < 3; f++) run_frame('1, 1'b0, f > 0);
  endtask

  task automatic t_empty_slots();
    run_frame(4'b1010, 1'b0, 1'b0);
    run_frame(4'b0000, 1'b0, 1'b0);
    run_frame(4'b0111, 1'b0, 1'b0);
    run_frame(4'b1110, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    run_frame('1, 1'b0, 1'b0);
    for (int f = 0; f < 4; f++) run_frame('1, 1'b0, 1'b1);
  endtask

  task automatic t_ignore();
    run_frame('1, 1'b1, 1'b0);
    run_frame(4'b0101, 1'b1, 1'b0);
    run_frame('1, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_full_frames();
    t_empty_slots();
    t_back_to_back();
    t_ignore();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule